// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns each bus access into at most one active-low select line. Four channels each hold a base address and a block size that is a power of two. A channel claims an access when the address bits above its block size equal the same bits of its base. Base bits below the block size are ignored, so every region sits on a multiple of its own size. The claiming channel also hands the bus sequencer its attributes for that access: the port width (8 or 16 bits), a wait-state count, and whether the access runs as a multiplexed 8-bit 8051-style cycle. Once the programmed number of wait clocks has elapsed, the block raises a one-cycle internal acknowledge.

Each channel can also refuse accesses made in user mode, refuse writes, or both. A refused access raises a bus error instead of a select. One channel, set by parameter, may mark its region for 8051-style cycles. Another channel may split its block into four equal quarters and drive one of four peripheral select lines in place of its own select. Software programs the channels through a plain write port. Each channel has two words: a base word and an option word.

An access begins when `bus_valid` is sampled high in the idle state. The decision is registered at that edge and held until `bus_valid` is sampled low. A new access needs `bus_valid` to be low for at least one edge in between.

Top module: `csel_decoder`

## Requirements
- R1: After reset every channel is disabled and all selects are high, with `bus_err` and `acc_ack` low. An access with no enabled channel drives nothing.
- R2: An enabled channel (option bit 0 = 1) whose base word matches the address above the block size drives its `cs_n` bit low. This happens on the first edge after `bus_valid` is sampled high. Base bits below the block size have no effect.
- R3: Option bits 12:8 hold k, and the block size is 2^k bytes. An address one past the top of the block is not claimed. A k of 24 or more claims every address.
- R4: When several enabled channels claim an address, the lowest-numbered one wins. Its attributes and protection alone apply.
- R5: `acc_wide` follows option bit 1 of the winning channel. `acc_mux8` follows option bit 13, but only when the winner is channel `MUX8_CH`; on any other channel that bit has no effect.
- R6: With option bit 2 set, an access with `bus_super` low raises `bus_err` and drives no select.
- R7: With option bit 3 set, an access with `bus_write` high raises `bus_err` and drives no select.
- R8: Option bits 7:4 hold a wait count N, from 0 to 15. It appears on `acc_ws`. `acc_ack` is high for exactly one cycle, starting N+1 edges after the select appears. A refused access gives no acknowledge.
- R9: On channel `PERIPH_CH` with option bit 14 set, the channel's own select stays high. Instead, `periph_n[i]` goes low, where i is address bits k-1:k-2.
- R10: One edge after `bus_valid` is sampled low, every select, `bus_err` and `acc_ack` are inactive.
- R11: A register write (`cfg_sel` 0 = base word, 1 = option word) takes effect at its edge. An access starting on that same edge is decoded with the settings from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 1 | 0 = base word, 1 = option word |
| cfg_wdata | input | 24 | Write data |
| bus_valid | input | 1 | Access in progress |
| bus_addr | input | 24 | Access byte address |
| bus_write | input | 1 | 1 = write access |
| bus_super | input | 1 | 1 = supervisor access |
| cs_n | output | 4 | Active-low channel selects |
| periph_n | output | 4 | Active-low peripheral selects from the subdecode |
| bus_err | output | 1 | Protection violation |
| acc_ack | output | 1 | One-cycle internal acknowledge |
| acc_wide | output | 1 | 1 = 16-bit port |
| acc_mux8 | output | 1 | 1 = multiplexed 8-bit cycle |
| acc_ws | output | 4 | Wait count of the current access |

## Verification
Two things can happen on the same edge: a register write, and the start of an access that decodes through the very channel being rewritten. The bench provokes this by raising `cfg_we` and `bus_valid` together. The write disables the channel, yet the access is expected to select it with its old attributes. The next access to the same address is then expected to fall through to the lower-priority catch-all channel. A second collision comes from overlapping regions. A read-only catch-all channel and a writable channel 0 both claim a write, and that write must complete on channel 0 with no error.

// File: rtl/csel_pkg.sv
// Package: shared types and field layout for the chip-select decoder.
// Assumes a 24-bit byte address and a 15-bit option word.
package csel_pkg;

    localparam int ADDR_W     = 24;
    localparam int WS_W       = 4;
    localparam int SIZE_W     = 5;
    localparam int NUM_PERIPH = 4;
    localparam int SUB_W      = $clog2(NUM_PERIPH);

    // Option word, MSB first: subdec(14) mux8(13) size(12:8) ws(7:4) ro(3) sup(2) wide(1) en(0)
    typedef struct packed {
        logic              subdec;
        logic              mux8;
        logic [SIZE_W-1:0] size_log2;
        logic [WS_W-1:0]   ws;
        logic              rd_only;
        logic              sup_only;
        logic              wide;
        logic              en;
    } ch_cfg_t;

    localparam int CFG_BITS = $bits(ch_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/csel_regs.sv
// Module: per-channel base and option registers written over a plain
// strobe port. Assumes ADDR_W >= CFG_BITS. All channels reset disabled.
module csel_regs
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CH_W-1:0]     cfg_ch,
    input  logic                cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   base_q [NUM_CH],
    output ch_cfg_t             cfg_q  [NUM_CH]
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Store the base or option word of channel i on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                cfg_q[i]  <= '0;
            end else if (cfg_we && cfg_ch == CH_W'(i)) begin
                if (cfg_sel)
                    cfg_q[i] <= ch_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
                else
                    base_q[i] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/csel_match.sv
// Module: address comparator for one channel. Compares only the bits at
// and above the block size and extracts the two address bits just below
// the block size for the peripheral subdecode. Purely combinational.
module csel_match
    import csel_pkg::*;
#(
    localparam int IDX_W = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              en,
    input  logic [SIZE_W-1:0] size_log2,
    output logic              hit,
    output logic [SUB_W-1:0]  sub
);

    logic [ADDR_W-1:0] mask;
    logic [IDX_W-1:0]  sub_lo;

    // Build the compare mask; a block as large as the space masks every bit.
    always_comb begin
        if (int'(size_log2) >= ADDR_W)
            mask = '0;
        else
            mask = {ADDR_W{1'b1}} << size_log2;
        hit = en && (((addr ^ base) & mask) == '0);
    end

    // Pick the quarter index from the two bits below the block size.
    always_comb begin
        if (int'(size_log2) < SUB_W)
            sub_lo = '0;
        else if (int'(size_log2) >= ADDR_W)
            sub_lo = IDX_W'(ADDR_W - SUB_W);
        else
            sub_lo = IDX_W'(int'(size_log2) - SUB_W);
        sub = addr[sub_lo +: SUB_W];
    end

endmodule

// File: rtl/csel_arbiter.sv
// Module: fixed-priority pick among hitting channels (lowest index wins)
// and protection check against the winner only. Combinational.
module csel_arbiter
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] hit,
    input  logic [SUB_W-1:0]  sub     [NUM_CH],
    input  logic [WS_W-1:0]   ws      [NUM_CH],
    input  logic [NUM_CH-1:0] wide,
    input  logic [NUM_CH-1:0] mux8,
    input  logic [NUM_CH-1:0] subdec,
    input  logic [NUM_CH-1:0] sup_only,
    input  logic [NUM_CH-1:0] rd_only,
    input  logic              bus_write,
    input  logic              bus_super,
    output logic              sel_any,
    output logic [CH_W-1:0]   sel_ch,
    output logic              sel_viol,
    output logic              sel_wide,
    output logic              sel_mux8,
    output logic              sel_subdec,
    output logic [WS_W-1:0]   sel_ws,
    output logic [SUB_W-1:0]  sel_sub
);

    // Scan from the highest channel down so the lowest hitting one is kept.
    always_comb begin
        sel_any    = 1'b0;
        sel_ch     = '0;
        sel_viol   = 1'b0;
        sel_wide   = 1'b0;
        sel_mux8   = 1'b0;
        sel_subdec = 1'b0;
        sel_ws     = '0;
        sel_sub    = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_any    = 1'b1;
                sel_ch     = CH_W'(i);
                sel_viol   = (sup_only[i] && !bus_super) || (rd_only[i] && bus_write);
                sel_wide   = wide[i];
                sel_mux8   = mux8[i];
                sel_subdec = subdec[i];
                sel_ws     = ws[i];
                sel_sub    = sub[i];
            end
        end
    end

endmodule

// File: rtl/csel_seq.sv
// Module: access sequencer. Registers the decode decision when an access
// starts, counts wait clocks, pulses the acknowledge, and releases every
// output once bus_valid is sampled low. Assumes bus_valid drops between accesses.
module csel_seq
    import csel_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int MUX8_CH   = 1,
    parameter int PERIPH_CH = 2,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  sel_any,
    input  logic [CH_W-1:0]       sel_ch,
    input  logic                  sel_viol,
    input  logic                  sel_wide,
    input  logic                  sel_mux8,
    input  logic                  sel_subdec,
    input  logic [WS_W-1:0]       sel_ws,
    input  logic [SUB_W-1:0]      sel_sub,
    output logic [NUM_CH-1:0]     cs_n,
    output logic [NUM_PERIPH-1:0] periph_n,
    output logic                  bus_err,
    output logic                  acc_ack,
    output logic                  acc_wide,
    output logic                  acc_mux8,
    output logic [WS_W-1:0]       acc_ws
);

    seq_state_t      state;
    logic [WS_W-1:0] wait_cnt;
    logic            is_mux_ch;
    logic            is_per_ch;

    // Decide whether the winner carries the channel-specific features.
    always_comb begin
        is_mux_ch = (sel_ch == CH_W'(MUX8_CH));
        is_per_ch = (sel_ch == CH_W'(PERIPH_CH));
    end

    // Access state machine with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            cs_n     <= '1;
            periph_n <= '1;
            bus_err  <= 1'b0;
            acc_ack  <= 1'b0;
            acc_wide <= 1'b0;
            acc_mux8 <= 1'b0;
            acc_ws   <= '0;
        end else begin
            acc_ack <= 1'b0;
            if (state != ST_IDLE && !bus_valid) begin
                state    <= ST_IDLE;
                wait_cnt <= '0;
                cs_n     <= '1;
                periph_n <= '1;
                bus_err  <= 1'b0;
                acc_wide <= 1'b0;
                acc_mux8 <= 1'b0;
                acc_ws   <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (bus_valid) begin
                            if (!sel_any) begin
                                state <= ST_HOLD;
                            end else if (sel_viol) begin
                                state   <= ST_FAULT;
                                bus_err <= 1'b1;
                            end else begin
                                state    <= ST_WAIT;
                                wait_cnt <= sel_ws;
                                acc_ws   <= sel_ws;
                                acc_wide <= sel_wide;
                                acc_mux8 <= is_mux_ch && sel_mux8;
                                if (is_per_ch && sel_subdec)
                                    periph_n <= ~(NUM_PERIPH'(1) << sel_sub);
                                else
                                    cs_n <= ~(NUM_CH'(1) << sel_ch);
                            end
                        end
                    end
                    ST_WAIT: begin
                        if (wait_cnt == '0) begin
                            acc_ack <= 1'b1;
                            state   <= ST_HOLD;
                        end else begin
                            wait_cnt <= wait_cnt - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csel_decoder.sv
// Module: top of the programmable chip-select decoder. Wires the register
// file, one comparator per channel, the priority arbiter and the sequencer.
// Assumes a 24-bit address space and up to 15 wait clocks per region.
module csel_decoder
    import csel_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int MUX8_CH   = 1,
    parameter int PERIPH_CH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_CH)-1:0]  cfg_ch,
    input  logic                       cfg_sel,
    input  logic [23:0]                cfg_wdata,
    input  logic                       bus_valid,
    input  logic [23:0]                bus_addr,
    input  logic                       bus_write,
    input  logic                       bus_super,
    output logic [NUM_CH-1:0]          cs_n,
    output logic [3:0]                 periph_n,
    output logic                       bus_err,
    output logic                       acc_ack,
    output logic                       acc_wide,
    output logic                       acc_mux8,
    output logic [3:0]                 acc_ws
);

    localparam int CH_W = $clog2(NUM_CH);

    logic [ADDR_W-1:0] base_q [NUM_CH];
    ch_cfg_t           cfg_q  [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [SUB_W-1:0]  sub    [NUM_CH];
    logic [WS_W-1:0]   ch_ws  [NUM_CH];
    logic [NUM_CH-1:0] ch_wide, ch_mux8, ch_subdec, ch_sup, ch_ro;

    logic              sel_any, sel_viol, sel_wide, sel_mux8, sel_subdec;
    logic [CH_W-1:0]   sel_ch;
    logic [WS_W-1:0]   sel_ws;
    logic [SUB_W-1:0]  sel_sub;

    csel_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .cfg_q     (cfg_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_match
        csel_match u_match (
            .addr      (bus_addr),
            .base      (base_q[i]),
            .en        (cfg_q[i].en),
            .size_log2 (cfg_q[i].size_log2),
            .hit       (hit[i]),
            .sub       (sub[i])
        );
        // Fan the remaining option fields of channel i out to the arbiter.
        always_comb begin
            ch_ws[i]     = cfg_q[i].ws;
            ch_wide[i]   = cfg_q[i].wide;
            ch_mux8[i]   = cfg_q[i].mux8;
            ch_subdec[i] = cfg_q[i].subdec;
            ch_sup[i]    = cfg_q[i].sup_only;
            ch_ro[i]     = cfg_q[i].rd_only;
        end
    end

    csel_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .hit        (hit),
        .sub        (sub),
        .ws         (ch_ws),
        .wide       (ch_wide),
        .mux8       (ch_mux8),
        .subdec     (ch_subdec),
        .sup_only   (ch_sup),
        .rd_only    (ch_ro),
        .bus_write  (bus_write),
        .bus_super  (bus_super),
        .sel_any    (sel_any),
        .sel_ch     (sel_ch),
        .sel_viol   (sel_viol),
        .sel_wide   (sel_wide),
        .sel_mux8   (sel_mux8),
        .sel_subdec (sel_subdec),
        .sel_ws     (sel_ws),
        .sel_sub    (sel_sub)
    );

    csel_seq #(
        .NUM_CH    (NUM_CH),
        .MUX8_CH   (MUX8_CH),
        .PERIPH_CH (PERIPH_CH)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .sel_any    (sel_any),
        .sel_ch     (sel_ch),
        .sel_viol   (sel_viol),
        .sel_wide   (sel_wide),
        .sel_mux8   (sel_mux8),
        .sel_subdec (sel_subdec),
        .sel_ws     (sel_ws),
        .sel_sub    (sel_sub),
        .cs_n       (cs_n),
        .periph_n   (periph_n),
        .bus_err    (bus_err),
        .acc_ack    (acc_ack),
        .acc_wide   (acc_wide),
        .acc_mux8   (acc_mux8),
        .acc_ws     (acc_ws)
    );

endmodule

// File: rtl/csel_decoder_chk.sv
// Checker: temporal properties on the decoder's outputs, bound to the top.
module csel_decoder_chk #(
    parameter int NUM_CH  = 4,
    parameter int MUX8_CH = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [NUM_CH-1:0] cs_n,
    input logic [3:0]        periph_n,
    input logic              bus_err,
    input logic              acc_ack,
    input logic              acc_mux8
);

    // R1: the cycle after reset is held, everything is inactive
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (&cs_n && &periph_n && !bus_err && !acc_ack));

    // R4 / R9: never more than one select line low
    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~cs_n, ~periph_n}));

    // R6 / R7: an error never comes with a select or an acknowledge
    a_r6_err_excludes_select: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (&cs_n && &periph_n && !acc_ack));

    // R8: acknowledge is a single-cycle pulse
    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |=> !acc_ack);

    // R8: acknowledge only while a select is held
    a_r8_ack_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> !(&cs_n && &periph_n));

    // R5: the multiplexed cycle flag only appears with the designated channel
    a_r5_mux8_channel: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mux8 |-> !cs_n[MUX8_CH]);

    // R10: dropping bus_valid releases everything one edge later
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (&cs_n && &periph_n && !bus_err && !acc_ack));

endmodule

bind csel_decoder csel_decoder_chk #(
    .NUM_CH  (NUM_CH),
    .MUX8_CH (MUX8_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .cs_n      (cs_n),
    .periph_n  (periph_n),
    .bus_err   (bus_err),
    .acc_ack   (acc_ack),
    .acc_mux8  (acc_mux8)
);

// File: tb/test_csel_decoder.sv
module test_csel_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic        cfg_sel = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic        bus_super = 1'b0;
    logic [3:0]  cs_n;
    logic [3:0]  periph_n;
    logic        bus_err;
    logic        acc_ack;
    logic        acc_wide;
    logic        acc_mux8;
    logic [3:0]  acc_ws;

    csel_decoder i_csel_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write), .bus_super(bus_super),
        .cs_n(cs_n), .periph_n(periph_n), .bus_err(bus_err), .acc_ack(acc_ack),
        .acc_wide(acc_wide), .acc_mux8(acc_mux8), .acc_ws(acc_ws)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [3:0] cs_n;
        logic [3:0] pn;
        logic       err;
        logic       wide;
        logic       mux8;
        int         ws;
        bit         ack;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_done = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic [3:0] c, input logic [3:0] p, input logic e,
                                input logic w, input logic m, input int ws, input string req);
        exp_t x;
        x.cs_n = c; x.pn = p; x.err = e; x.wide = w; x.mux8 = m; x.ws = ws;
        x.ack  = (c != 4'hF) || (p != 4'hF);
        x.req  = req;
        return x;
    endfunction

    task automatic cfg_write(input int ch, input bit sel, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: push the expected result, start the access, optionally with a
    // simultaneous register write, then end it and check the release.
    task automatic access(input logic [23:0] a, input bit wr, input bit sup, input exp_t e,
                          input bit cw = 1'b0, input int cw_ch = 0, input bit cw_sel = 1'b0,
                          input logic [23:0] cw_data = '0);
        @(negedge clk);
        mon_done = 1'b0;
        sb_q.push_back(e);
        bus_addr = a; bus_write = wr; bus_super = sup; bus_valid = 1'b1;
        if (cw) begin
            cfg_we = 1'b1; cfg_ch = 2'(cw_ch); cfg_sel = cw_sel; cfg_wdata = cw_data;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        wait (mon_done);
        @(negedge clk);
        bus_valid = 1'b0;
        @(negedge clk);
        check("R10", "released", int'({cs_n, periph_n, bus_err, acc_ack}), 'h3FC);
    endtask

    // Monitor: pop each expected item and compare it with what the design produces.
    initial begin
        forever begin
            exp_t e;
            int   cnt;
            wait (sb_q.size() != 0 && bus_valid);
            @(negedge clk);
            e = sb_q.pop_front();
            check(e.req, "cs_n", int'(cs_n), int'(e.cs_n));
            check(e.req, "periph_n", int'(periph_n), int'(e.pn));
            check(e.req, "bus_err", int'(bus_err), int'(e.err));
            check(e.req, "acc_wide", int'(acc_wide), int'(e.wide));
            check(e.req, "acc_mux8", int'(acc_mux8), int'(e.mux8));
            if (e.ack) begin
                check(e.req, "acc_ws", int'(acc_ws), e.ws);
                cnt = 0;
                while (!acc_ack && cnt < 40) begin
                    @(negedge clk);
                    cnt++;
                end
                check("R8", "ack delay", cnt, e.ws + 1);
                @(negedge clk);
                check("R8", "ack width", int'(acc_ack), 0);
            end else begin
                @(negedge clk);
                check(e.req, "no ack", int'(acc_ack), 0);
            end
            mon_done = 1'b1;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset outputs", int'({cs_n, periph_n, bus_err, acc_ack}), 'h3FC);
        access(24'h000000, 1'b0, 1'b1, mk(4'hF, 4'hF, 0, 0, 0, 0, "R1"));

        // ch0: 64 KB at 0, 16-bit, 2 waits
        cfg_write(0, 0, 24'h000000); cfg_write(0, 1, 24'h001023);
        // ch1: 4 KB at 0x100000, 8-bit, multiplexed cycles, 0 waits
        cfg_write(1, 0, 24'h100000); cfg_write(1, 1, 24'h002C01);
        // ch2: 256 B at 0x200000, subdecode, 16-bit, 5 waits
        cfg_write(2, 0, 24'h200000); cfg_write(2, 1, 24'h004853);
        // ch3: 64 KB at 0x30xxxx (low base bits junk), supervisor + read-only, 15 waits
        cfg_write(3, 0, 24'h3000AB); cfg_write(3, 1, 24'h0010FD);

        access(24'h001234, 1'b0, 1'b1, mk(4'hE, 4'hF, 0, 1, 0, 2, "R2"));
        access(24'h00FFFF, 1'b1, 1'b0, mk(4'hE, 4'hF, 0, 1, 0, 2, "R3"));
        access(24'h010000, 1'b0, 1'b1, mk(4'hF, 4'hF, 0, 0, 0, 0, "R3"));
        access(24'h100FFE, 1'b0, 1'b0, mk(4'hD, 4'hF, 0, 0, 1, 0, "R5"));
        access(24'h101000, 1'b0, 1'b1, mk(4'hF, 4'hF, 0, 0, 0, 0, "R3"));
        access(24'h2000C0, 1'b0, 1'b1, mk(4'hF, 4'h7, 0, 1, 0, 5, "R9"));
        access(24'h200040, 1'b1, 1'b0, mk(4'hF, 4'hD, 0, 1, 0, 5, "R9"));
        access(24'h30FF00, 1'b0, 1'b1, mk(4'h7, 4'hF, 0, 0, 0, 15, "R2"));
        access(24'h30FF00, 1'b0, 1'b0, mk(4'hF, 4'hF, 1, 0, 0, 0, "R6"));
        access(24'h300010, 1'b1, 1'b1, mk(4'hF, 4'hF, 1, 0, 0, 0, "R7"));

        // ch3 becomes a read-only catch-all (k = 24), user allowed, 0 waits
        cfg_write(3, 0, 24'h000000); cfg_write(3, 1, 24'h001809);
        access(24'h001000, 1'b0, 1'b1, mk(4'hE, 4'hF, 0, 1, 0, 2, "R4"));
        access(24'h500000, 1'b0, 1'b0, mk(4'h7, 4'hF, 0, 0, 0, 0, "R3"));
        access(24'h500000, 1'b1, 1'b0, mk(4'hF, 4'hF, 1, 0, 0, 0, "R7"));
        access(24'h000010, 1'b1, 1'b0, mk(4'hE, 4'hF, 0, 1, 0, 2, "R4"));
        access(24'h100000, 1'b0, 1'b0, mk(4'hD, 4'hF, 0, 0, 1, 0, "R4"));

        // multiplexed-cycle bit on a channel that is not MUX8_CH has no effect
        cfg_write(0, 1, 24'h003023);
        access(24'h000020, 1'b0, 1'b1, mk(4'hE, 4'hF, 0, 1, 0, 2, "R5"));

        // R11: disabling ch1 on the same edge the access starts
        access(24'h100004, 1'b0, 1'b1, mk(4'hD, 4'hF, 0, 0, 1, 0, "R11"),
               1'b1, 1, 1'b1, 24'h002C00);
        access(24'h100004, 1'b0, 1'b1, mk(4'h7, 4'hF, 0, 0, 0, 0, "R11"));

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule